// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel character at a time into an asynchronous serial frame on an idle-high line. A six-bit line-format register chooses the character length (5 to 8 bits), the stop period (one, one and a half, or two bit times) and the parity treatment (none, odd, even, or a parity bit forced to 1 or to 0). Characters enter through a valid/ready handshake. The line advances only on a bit-rate enable strobe that runs at a fixed multiple of the bit rate, so the baud generator stays outside the block.

Each frame has three or four parts in this order:
- a start bit at 0;
- the data bits, least significant first;
- the parity bit, when parity is enabled;
- the stop period at 1.

The format register is copied when a character is accepted. Rewriting the register mid-frame therefore only affects the next frame. Data bits above the selected length take no part in the frame.

Top module: `framer_top`

## Requirements
- R1: After reset the serial line is 1, `busy` is 0, `txReady` is 1, and the format register holds 0, which means a 5-bit character, one stop bit and no parity.
- R2: While idle the line stays at 1 and `txReady` is 1. A character is accepted on a clock edge where `txValid` and `txReady` are both 1. `txReady` stays 0 for the whole frame.
- R3: The start bit (0) appears on the cycle after acceptance. The data bits follow, least significant first. Every bit other than the stop period lasts `TICKS_PER_BIT` strobes.
- R4: Format bits [1:0] select the character length: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8.
- R5: With format bit [2] at 0 the stop period is one bit time. With bit [2] at 1 it is two bit times, except for 5-bit characters, where it is one and a half bit times (`TICKS_PER_BIT*3/2` strobes).
- R6: With format bit [3] at 1, one parity bit is sent after the data bits. With bit [3] at 0, no parity bit is sent.
- R7: Format bits [5:4] select the parity value:
  - 00 is odd: the data ones plus the parity bit give an odd count.
  - 01 is even: that count is even.
  - 10 forces the parity bit to 1.
  - 11 forces the parity bit to 0.
- R8: The format register is sampled at acceptance. A register write during a frame does not change that frame.
- R9: Data bits above the selected length are not sent and do not enter the parity calculation.
- R10: While a frame is in progress, the line changes only on the cycle after a clock edge on which `baudTick` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | Bit-rate enable strobe, `TICKS_PER_BIT` per bit |
| cfgWe | input | 1 | Write enable for the format register |
| cfgWdata | input | 6 | Format value: [1:0] length, [2] stop, [3] parity enable, [5:4] parity mode |
| txData | input | 8 | Character to send |
| txValid | input | 1 | Character offered |
| txReady | output | 1 | Framer idle and able to accept |
| serOut | output | 1 | Serial line, 1 when idle |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the framer with `TICKS_PER_BIT` set to 4 and raises the strobe on every third clock. This keeps each frame under about 150 cycles, so the bench can sweep all 64 format codes with two data patterns. The half-bit stop period is still 2 strobes, so the fractional stop timing stays observable. The bench also builds its own expected level for every strobe slot, which lets it check the hold between strobes on each cycle of every frame.

// File: rtl/framer_pkg.sv
package framer_pkg;

  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  // Packed so that bit positions match the format register layout.
  typedef struct packed {
    logic [1:0] parMode;  // [5:4]
    logic       parEn;    // [3]
    logic       stopSel;  // [2]
    logic [1:0] lenCode;  // [1:0]
  } lineFmt_t;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   load;
    logic   shift;
    phase_e phase;
  } dpCtl_t;

  function automatic logic [CNT_W-1:0] lenFromCode(input logic [1:0] code);
    return CNT_W'(5) + CNT_W'(code);
  endfunction

endpackage

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int TICK_W        = $clog2(2 * TICKS_PER_BIT) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  lineFmt_t               fmtIn,
  input  logic [DATA_W-1:0]      dataIn,
  output logic                   serOut,
  output logic [CNT_W-1:0]       dataBits,
  output logic                   parEn,
  output logic [TICK_W-1:0]      stopTicks
);

  localparam logic [TICK_W-1:0] STOP_ONE  = TICK_W'(TICKS_PER_BIT);
  localparam logic [TICK_W-1:0] STOP_HALF = TICK_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [TICK_W-1:0] STOP_TWO  = TICK_W'(2 * TICKS_PER_BIT);

  lineFmt_t          fmtSnap;
  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;
  logic [DATA_W-1:0] keepMask;
  logic [DATA_W-1:0] maskedIn;
  logic [CNT_W-1:0]  inBits;
  logic              onesOdd;
  logic              parityNext;

  assign inBits = lenFromCode(fmtIn.lenCode);

  // Lanes above the selected length are cleared before use.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keepMask[i] = (CNT_W'(i) < inBits);
  end

  assign maskedIn = dataIn & keepMask;
  assign onesOdd  = ^maskedIn;

  always_comb begin
    unique case (fmtIn.parMode)
      2'b00:   parityNext = ~onesOdd;
      2'b01:   parityNext = onesOdd;
      2'b10:   parityNext = 1'b1;
      default: parityNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtSnap   <= '0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else if (ctl.load) begin
      fmtSnap   <= fmtIn;
      shiftReg  <= maskedIn;
      parityBit <= parityNext;
    end else if (ctl.shift) begin
      shiftReg  <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  assign dataBits = lenFromCode(fmtSnap.lenCode);
  assign parEn    = fmtSnap.parEn;

  always_comb begin
    if (!fmtSnap.stopSel)             stopTicks = STOP_ONE;
    else if (fmtSnap.lenCode == 2'b00) stopTicks = STOP_HALF;
    else                              stopTicks = STOP_TWO;
  end

  always_comb begin
    unique case (ctl.phase)
      PH_START:  serOut = 1'b0;
      PH_DATA:   serOut = shiftReg[0];
      PH_PARITY: serOut = parityBit;
      default:   serOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int TICK_W        = $clog2(2 * TICKS_PER_BIT) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic               txValid,
  input  logic [CNT_W-1:0]   dataBits,
  input  logic               parEn,
  input  logic [TICK_W-1:0]  stopTicks,
  output dpCtl_t             ctl,
  output logic               txReady,
  output logic               busy
);

  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);

  phase_e            phase, phaseNx;
  logic [TICK_W-1:0] tickCnt, tickNx;
  logic [CNT_W-1:0]  bitCnt, bitNx;
  logic              bitEnd;
  logic              stopEnd;

  assign bitEnd  = baudTick && (tickCnt == LAST_TICK);
  assign stopEnd = baudTick && (tickCnt == stopTicks - 1'b1);

  always_comb begin
    phaseNx   = phase;
    tickNx    = baudTick ? tickCnt + 1'b1 : tickCnt;
    bitNx     = bitCnt;
    ctl.load  = 1'b0;
    ctl.shift = 1'b0;
    ctl.phase = phase;
    unique case (phase)
      PH_IDLE: begin
        tickNx = '0;
        if (txValid) begin
          ctl.load = 1'b1;
          phaseNx  = PH_START;
        end
      end
      PH_START: begin
        if (bitEnd) begin
          phaseNx = PH_DATA;
          tickNx  = '0;
          bitNx   = '0;
        end
      end
      PH_DATA: begin
        if (bitEnd) begin
          ctl.shift = 1'b1;
          tickNx    = '0;
          if (bitCnt == dataBits - 1'b1) begin
            phaseNx = parEn ? PH_PARITY : PH_STOP;
          end else begin
            bitNx = bitCnt + 1'b1;
          end
        end
      end
      PH_PARITY: begin
        if (bitEnd) begin
          phaseNx = PH_STOP;
          tickNx  = '0;
        end
      end
      PH_STOP: begin
        if (stopEnd) begin
          phaseNx = PH_IDLE;
          tickNx  = '0;
        end
      end
      default: phaseNx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      phase   <= phaseNx;
      tickCnt <= tickNx;
      bitCnt  <= bitNx;
    end
  end

  assign txReady = (phase == PH_IDLE);
  assign busy    = (phase != PH_IDLE);

endmodule

// File: rtl/framer_top.sv
module framer_top
  import framer_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic                cfgWe,
  input  logic [5:0]          cfgWdata,
  input  logic [DATA_W-1:0]   txData,
  input  logic                txValid,
  output logic                txReady,
  output logic                serOut,
  output logic                busy
);

  localparam int TICK_W = $clog2(2 * TICKS_PER_BIT) + 1;

  lineFmt_t          cfgReg;
  dpCtl_t            ctl;
  logic [CNT_W-1:0]  dataBits;
  logic              parEn;
  logic [TICK_W-1:0] stopTicks;

  always_ff @(posedge clk) begin
    if (!rstN)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= lineFmt_t'(cfgWdata);
  end

  framer_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .TICK_W(TICK_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .txValid   (txValid),
    .dataBits  (dataBits),
    .parEn     (parEn),
    .stopTicks (stopTicks),
    .ctl       (ctl),
    .txReady   (txReady),
    .busy      (busy)
  );

  framer_dp #(.TICKS_PER_BIT(TICKS_PER_BIT), .TICK_W(TICK_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .fmtIn     (cfgReg),
    .dataIn    (txData),
    .serOut    (serOut),
    .dataBits  (dataBits),
    .parEn     (parEn),
    .stopTicks (stopTicks)
  );

endmodule

// File: rtl/framer_chk.sv
module framer_chk #(
  parameter int TICKS_PER_BIT = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       baudTick,
  input logic [5:0] cfgReg,
  input logic       txValid,
  input logic       txReady,
  input logic       serOut,
  input logic       busy
);

  logic [5:0]  fmtSeen;
  logic [15:0] tickSum;
  logic [15:0] expTicks;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtSeen <= '0;
      tickSum <= '0;
    end else if (txValid && txReady) begin
      fmtSeen <= cfgReg;
      tickSum <= '0;
    end else if (busy && baudTick) begin
      tickSum <= tickSum + 16'd1;
    end
  end

  always_comb begin
    int bitsN;
    int stopN;
    bitsN = 5 + int'(fmtSeen[1:0]);
    if (!fmtSeen[2])             stopN = TICKS_PER_BIT;
    else if (fmtSeen[1:0] == 2'b00) stopN = TICKS_PER_BIT + TICKS_PER_BIT / 2;
    else                         stopN = 2 * TICKS_PER_BIT;
    expTicks = 16'(TICKS_PER_BIT * (1 + bitsN + int'(fmtSeen[3])) + stopN);
  end

  assert_idle_mark_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (serOut && txReady));

  assert_start_after_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (busy && !serOut && !txReady));

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(baudTick)) |-> $stable(serOut));

  assert_frame_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (tickSum == expTicks));

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !txReady);

endmodule

bind framer_top framer_chk #(.TICKS_PER_BIT(TICKS_PER_BIT)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .baudTick (baudTick),
  .cfgReg   (cfgReg),
  .txValid  (txValid),
  .txReady  (txReady),
  .serOut   (serOut),
  .busy     (busy)
);

// File: tb/framer_top_tb_top.sv
`timescale 1ns/1ps
module framer_top_tb_top;

  localparam int TPB = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       cfgWe = 1'b0;
  logic [5:0] cfgWdata = '0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       serOut;
  logic       busy;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  framer_top #(.TICKS_PER_BIT(TPB)) dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .txData(txData), .txValid(txValid),
    .txReady(txReady), .serOut(serOut), .busy(busy)
  );

  task automatic report(input bit ok, input string tag, input string what,
                        input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Sends one character and checks the line level on every cycle of the frame.
  task automatic runFrame(input logic [5:0] code, input bit writeCfg,
                          input logic [7:0] data, input bit midChange,
                          input logic [5:0] midCode, input string tag);
    logic expLvl [0:127];
    int   total, nBits, stopN, tickIdx, cyc, badAt, badAct, badExp;
    logic ones, par;
    total = 0;
    nBits = 5 + int'(code[1:0]);
    for (int k = 0; k < TPB; k++) begin expLvl[total] = 1'b0; total++; end
    ones = 1'b0;
    for (int b = 0; b < nBits; b++) begin
      ones ^= data[b];
      for (int k = 0; k < TPB; k++) begin expLvl[total] = data[b]; total++; end
    end
    if (code[3]) begin
      case (code[5:4])
        2'b00:   par = ~ones;
        2'b01:   par = ones;
        2'b10:   par = 1'b1;
        default: par = 1'b0;
      endcase
      for (int k = 0; k < TPB; k++) begin expLvl[total] = par; total++; end
    end
    if (!code[2])               stopN = TPB;
    else if (code[1:0] == 2'b00) stopN = TPB + TPB / 2;
    else                        stopN = 2 * TPB;
    for (int k = 0; k < stopN; k++) begin expLvl[total] = 1'b1; total++; end

    @(negedge clk);
    if (writeCfg) begin
      cfgWe = 1'b1; cfgWdata = code;
      @(negedge clk);
      cfgWe = 1'b0;
    end
    report(txReady && !busy && serOut, tag, "idle before frame", int'(txReady), 1);
    txData = data; txValid = 1'b1; baudTick = 1'b0;
    @(negedge clk);
    txValid = 1'b0; txData = ~data;
    tickIdx = 0; cyc = 0; badAt = -1; badAct = 0; badExp = 0;
    while (tickIdx < total && cyc < 4000) begin
      cfgWe = 1'b0;
      if (badAt < 0 && (serOut !== expLvl[tickIdx] || !busy || txReady)) begin
        badAt = tickIdx; badAct = int'(serOut); badExp = int'(expLvl[tickIdx]);
      end
      if (midChange && tickIdx == 2 * TPB && cyc % 3 == 0) begin
        cfgWe = 1'b1; cfgWdata = midCode;
      end
      baudTick = (cyc % 3 == 2);
      if (baudTick) tickIdx++;
      cyc++;
      @(negedge clk);
    end
    baudTick = 1'b0; cfgWe = 1'b0;
    report(badAt < 0, tag, $sformatf("line level at strobe slot %0d", badAt), badAct, badExp);
    report(!busy && txReady && serOut, tag, "idle after frame", int'(busy), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    report(serOut == 1'b1, "R1", "serOut after reset", int'(serOut), 1);
    report(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    report(txReady == 1'b1, "R1", "txReady after reset", int'(txReady), 1);
    // Default format: 5 bits, one stop, no parity.
    runFrame(6'h00, 1'b0, 8'h16, 1'b0, 6'h00, "R1");
  endtask

  task automatic testLengths();
    for (int c = 0; c < 4; c++) runFrame(6'(c), 1'b1, 8'hA5, 1'b0, 6'h00, "R4");
  endtask

  task automatic testStops();
    for (int c = 0; c < 4; c++) runFrame(6'(4 + c), 1'b1, 8'h5A, 1'b0, 6'h00, "R5");
  endtask

  task automatic testParity();
    runFrame(6'b000011, 1'b1, 8'h81, 1'b0, 6'h00, "R6");
    for (int m = 0; m < 4; m++) begin
      runFrame({2'(m), 4'b1011}, 1'b1, 8'h07, 1'b0, 6'h00, "R7");
      runFrame({2'(m), 4'b1011}, 1'b1, 8'h03, 1'b0, 6'h00, "R7");
    end
  endtask

  task automatic testMidChange();
    runFrame(6'b011011, 1'b1, 8'hC9, 1'b1, 6'b100100, "R8");
    runFrame(6'b000000, 1'b1, 8'h0D, 1'b1, 6'b111111, "R8");
  endtask

  task automatic testHighBits();
    runFrame(6'b011000, 1'b1, 8'hE0, 1'b0, 6'h00, "R9");
    runFrame(6'b001001, 1'b1, 8'hC1, 1'b0, 6'h00, "R9");
    runFrame(6'b001010, 1'b1, 8'h80, 1'b0, 6'h00, "R9");
  endtask

  task automatic testSweep();
    for (int c = 0; c < 64; c++) begin
      runFrame(6'(c), 1'b1, 8'h3C, 1'b0, 6'h00, "R10");
      runFrame(6'(c), 1'b1, 8'hC3, 1'b0, 6'h00, "R3");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLengths();
    testStops();
    testParity();
    testMidChange();
    testHighBits();
    testSweep();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule